// File: doc/BRIEF.md
# Tag-Tracked Operand Capture Unit

This block keeps a small register file in which every register may carry a pending producer tag. It also holds one operand slot for an instruction that is in flight. When an instruction is decoded it reads three source registers. For each source that holds a settled value, the slot stores that value. For each source still awaiting a result, the slot stores the producer's tag instead. If the decoded instruction writes a destination, a wrapping counter issues it a fresh tag, and that tag is stamped on the destination register.

A shared result bus carries a tag and a value. Every cycle, the register file and the slot compare the bus tag with the tags they hold. When a tag matches, the register takes the value and drops its pending mark, and the slot fills in the missing operand. Once all three operands hold values, the slot reports that it is ready. A consumer then empties the slot with a take pulse.

The slot has three states. S_EMPTY means no instruction is held. S_WAIT means at least one operand still holds a tag. S_FULL means every operand holds a value. The transitions are:
- load: a decode from any state enters S_FULL or S_WAIT, depending on the operands it read.
- fill: S_WAIT moves to S_FULL when the last missing operand is captured from the bus.
- drain: a take with no decode in the same cycle moves any state to S_EMPTY.

Top module: `opcap_top`

## Requirements
- R1: After reset, no register is pending and every register holds the value 0. The slot is in S_EMPTY with op_have = 0 and slot_ready = 0, and dec_tag = 0.
- R2: A decode with dec_has_dst = 1 is given the tag currently shown on dec_tag, and dec_tag then advances by one modulo 16, so 15 is followed by 0. A decode with dec_has_dst = 0 leaves dec_tag unchanged.
- R3: A source register that is not pending places its value in its operand field, and that operand's op_have bit is 1 from the cycle after the decode.
- R4: A source register that is pending places its 4-bit tag in bits [3:0] of its operand field, with all higher bits 0, and that operand's op_have bit is 0.
- R5: In S_WAIT, a result with res_valid = 1 whose res_tag equals a missing operand's tag writes res_data into that operand and sets its op_have bit from the next cycle. Several operands may be filled in the same cycle.
- R6: A result whose tag equals a register's pending tag writes the value into that register and clears its pending mark in the same edge, so later readers receive the value.
- R7: A result carrying an older tag leaves a register alone if a newer writer has re-stamped it: the register stays pending with the newer tag.
- R8: A result broadcast in the same cycle as a decode that reads the matching pending register is forwarded, so the operand is loaded as a value with op_have = 1.
- R9: slot_ready is 1 exactly when all three op_have bits are 1. A take with no decode clears op_have, the operand data and slot_ready.
- R10: A result whose tag matches no missing operand changes neither the operand data nor op_have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode strobe; loads the slot |
| dec_src | input | 9 | Three source register indices, operand i in bits [3i+2:3i] |
| dec_has_dst | input | 1 | The decoded instruction writes a destination |
| dec_dst | input | 3 | Destination register index |
| dec_tag | output | 4 | Tag given to the next instruction that writes a destination |
| res_valid | input | 1 | Result bus carries a result this cycle |
| res_tag | input | 4 | Tag of the producer on the result bus |
| res_data | input | 64 | Value on the result bus |
| take | input | 1 | Consumer empties the slot |
| op_data | output | 192 | Three operand fields, operand i in bits [64i+63:64i] |
| op_have | output | 3 | Per-operand flag: 1 when the field holds a value, 0 when it holds a tag |
| slot_ready | output | 1 | All three operands hold values |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before anything is driven. They also assume that decode, take and result inputs stay stable around the sampling edge. Tags are assumed to be reused only after the earlier producer with that tag has broadcast its result, so a tag on the bus never refers to two different producers. The stimulus issues at most sixteen tags between the results that retire them. It drives every input half a period away from the rising edge, and decodes only after the previous contents have been checked.

// File: rtl/opcap_pkg.sv
package opcap_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_WAIT  = 2'd1,
        S_FULL  = 2'd2
    } slot_state_t;
endpackage

// File: rtl/opcap_tag_counter.sv
module opcap_tag_counter #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [TW-1:0] tag
);
    logic [TW-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (advance) begin
            tag_q <= tag_q + 1'b1;
        end
    end

    assign tag = tag_q;
endmodule

// File: rtl/opcap_regfile.sv
module opcap_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 64,
    parameter int TW   = 4,
    parameter int NSRC = 3,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RW-1:0]      wr_idx,
    input  logic [TW-1:0]      wr_tag,
    input  logic [NSRC*RW-1:0] rd_idx,
    input  logic               res_valid,
    input  logic [TW-1:0]      res_tag,
    input  logic [DW-1:0]      res_data,
    output logic [NSRC*DW-1:0] rd_data,
    output logic [NSRC-1:0]    rd_have
);
    logic [DW-1:0]   val_q  [NREG];
    logic [TW-1:0]   tag_q  [NREG];
    logic [NREG-1:0] pend_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic bus_hit;
        assign bus_hit = res_valid && pend_q[r] && (tag_q[r] == res_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[r] <= 1'b0;
                tag_q[r]  <= '0;
                val_q[r]  <= '0;
            end else begin
                if (wr_en && (wr_idx == RW'(r))) begin
                    pend_q[r] <= 1'b1;
                    tag_q[r]  <= wr_tag;
                end else if (bus_hit) begin
                    pend_q[r] <= 1'b0;
                end
                if (bus_hit) begin
                    val_q[r] <= res_data;
                end
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        logic [RW-1:0] idx;
        assign idx = rd_idx[s*RW +: RW];

        always_comb begin
            if (!pend_q[idx]) begin
                rd_have[s]           = 1'b1;
                rd_data[s*DW +: DW]  = val_q[idx];
            end else if (res_valid && (res_tag == tag_q[idx])) begin
                rd_have[s]           = 1'b1;
                rd_data[s*DW +: DW]  = res_data;
            end else begin
                rd_have[s]           = 1'b0;
                rd_data[s*DW +: DW]  = {{(DW-TW){1'b0}}, tag_q[idx]};
            end
        end
    end
endmodule

// File: rtl/opcap_slot.sv
module opcap_slot
    import opcap_pkg::*;
#(
    parameter int DW   = 64,
    parameter int TW   = 4,
    parameter int NSRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NSRC*DW-1:0] load_data,
    input  logic [NSRC-1:0]    load_have,
    input  logic               take,
    input  logic               res_valid,
    input  logic [TW-1:0]      res_tag,
    input  logic [DW-1:0]      res_data,
    output logic [NSRC*DW-1:0] op_data,
    output logic [NSRC-1:0]    op_have,
    output logic               ready
);
    slot_state_t        state_q, state_d;
    logic [NSRC*DW-1:0] data_q, data_d;
    logic [NSRC-1:0]    have_q, have_d;
    logic [NSRC-1:0]    grab;

    for (genvar i = 0; i < NSRC; i++) begin : g_snoop
        assign grab[i] = (state_q == S_WAIT) && res_valid && !have_q[i] &&
                         (data_q[i*DW +: TW] == res_tag);
    end

    always_comb begin
        data_d  = data_q;
        have_d  = have_q;
        state_d = state_q;
        if (load) begin
            data_d  = load_data;
            have_d  = load_have;
            state_d = (&load_have) ? S_FULL : S_WAIT;
        end else if (take) begin
            data_d  = '0;
            have_d  = '0;
            state_d = S_EMPTY;
        end else begin
            unique case (state_q)
                S_EMPTY: state_d = S_EMPTY;
                S_WAIT: begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (grab[i]) begin
                            data_d[i*DW +: DW] = res_data;
                            have_d[i]          = 1'b1;
                        end
                    end
                    state_d = (&have_d) ? S_FULL : S_WAIT;
                end
                S_FULL:  state_d = S_FULL;
                default: state_d = S_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            data_q  <= '0;
            have_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
            have_q  <= have_d;
        end
    end

    always_comb begin
        op_data = data_q;
        op_have = have_q;
        ready   = (state_q == S_FULL);
    end
endmodule

// File: rtl/opcap_top.sv
module opcap_top #(
    parameter int NREG = 8,
    parameter int DW   = 64,
    parameter int TW   = 4,
    parameter int NSRC = 3,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [NSRC*RW-1:0] dec_src,
    input  logic               dec_has_dst,
    input  logic [RW-1:0]      dec_dst,
    output logic [TW-1:0]      dec_tag,
    input  logic               res_valid,
    input  logic [TW-1:0]      res_tag,
    input  logic [DW-1:0]      res_data,
    input  logic               take,
    output logic [NSRC*DW-1:0] op_data,
    output logic [NSRC-1:0]    op_have,
    output logic               slot_ready
);
    logic               stamp;
    logic [NSRC*DW-1:0] rd_data;
    logic [NSRC-1:0]    rd_have;

    assign stamp = dec_valid && dec_has_dst;

    opcap_tag_counter #(.TW(TW)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (stamp),
        .tag     (dec_tag)
    );

    opcap_regfile #(.NREG(NREG), .DW(DW), .TW(TW), .NSRC(NSRC)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stamp),
        .wr_idx    (dec_dst),
        .wr_tag    (dec_tag),
        .rd_idx    (dec_src),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .rd_data   (rd_data),
        .rd_have   (rd_have)
    );

    opcap_slot #(.DW(DW), .TW(TW), .NSRC(NSRC)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dec_valid),
        .load_data (rd_data),
        .load_have (rd_have),
        .take      (take),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .op_data   (op_data),
        .op_have   (op_have),
        .ready     (slot_ready)
    );
endmodule

// File: rtl/opcap_chk.sv
module opcap_chk #(
    parameter int NSRC = 3,
    parameter int TW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic            dec_has_dst,
    input logic [TW-1:0]   dec_tag,
    input logic            take,
    input logic [NSRC-1:0] op_have,
    input logic            slot_ready
);
    assert_ready_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ready == (&op_have));

    assert_take_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !dec_valid) |=> (op_have == '0 && !slot_ready));

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_has_dst) |=> (dec_tag == TW'($past(dec_tag) + 1'b1)));

    assert_tag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && dec_has_dst) |=> $stable(dec_tag));

    assert_have_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !take) |=> ((op_have & $past(op_have)) == $past(op_have)));
endmodule

bind opcap_top opcap_chk #(.NSRC(NSRC), .TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_has_dst (dec_has_dst),
    .dec_tag     (dec_tag),
    .take        (take),
    .op_have     (op_have),
    .slot_ready  (slot_ready)
);

// File: tb/opcap_top_tb_top.sv
`timescale 1ns/1ps
module opcap_top_tb_top;
    localparam int NREG = 8;
    localparam int DW   = 64;
    localparam int TW   = 4;
    localparam int NSRC = 3;
    localparam int RW   = 3;
    localparam int VW   = 60;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               dec_valid = 1'b0;
    logic [NSRC*RW-1:0] dec_src = '0;
    logic               dec_has_dst = 1'b0;
    logic [RW-1:0]      dec_dst = '0;
    logic [TW-1:0]      dec_tag;
    logic               res_valid = 1'b0;
    logic [TW-1:0]      res_tag = '0;
    logic [DW-1:0]      res_data = '0;
    logic               take = 1'b0;
    logic [NSRC*DW-1:0] op_data;
    logic [NSRC-1:0]    op_have;
    logic               slot_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    opcap_top dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .dec_has_dst(dec_has_dst), .dec_dst(dec_dst), .dec_tag(dec_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .take(take), .op_data(op_data), .op_have(op_have), .slot_ready(slot_ready)
    );

    // Row: dv, s0, s1, s2, has_dst, dst, rv, rtag, rdata16, take, exp_have, exp_rdy, exp_tag, exp_d0
    localparam logic [VW-1:0] TBL [13] = '{
        {1'b1, 3'd0, 3'd0, 3'd0, 1'b1, 3'd1, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b111, 1'b1, 4'd1, 16'h0000}, // R1 R2 R3
        {1'b1, 3'd1, 3'd0, 3'd0, 1'b1, 3'd2, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b110, 1'b0, 4'd2, 16'h0000}, // R4
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd0, 16'hAAAA, 1'b0, 3'b111, 1'b1, 4'd2, 16'hAAAA}, // R5
        {1'b1, 3'd2, 3'd1, 3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b110, 1'b0, 4'd2, 16'h0001}, // R2 hold, R4, R6
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd5, 16'h1234, 1'b0, 3'b110, 1'b0, 4'd2, 16'h0001}, // R10
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd1, 16'hBEEF, 1'b0, 3'b111, 1'b1, 4'd2, 16'hBEEF}, // R5
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 3'b000, 1'b0, 4'd2, 16'h0000}, // R9 take
        {1'b1, 3'd1, 3'd2, 3'd0, 1'b1, 3'd3, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b111, 1'b1, 4'd3, 16'hAAAA}, // R6
        {1'b1, 3'd3, 3'd0, 3'd0, 1'b1, 3'd3, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b110, 1'b0, 4'd4, 16'h0002}, // R4
        {1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd2, 16'h5555, 1'b0, 3'b111, 1'b1, 4'd4, 16'h5555}, // R5 stale tag
        {1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b110, 1'b0, 4'd4, 16'h0003}, // R7
        {1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd3, 16'h7777, 1'b0, 3'b111, 1'b1, 4'd4, 16'h7777}, // R8
        {1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 3'b111, 1'b1, 4'd4, 16'h7777}  // R6
    };

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dec_valid = 1'b0; dec_has_dst = 1'b0; res_valid = 1'b0; take = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 have", 192'(op_have), 192'(0));
        check("R1 ready", 192'(slot_ready), 192'(0));
        check("R1 tag", 192'(dec_tag), 192'(0));

        for (int k = 0; k < 13; k++) begin
            logic [VW-1:0] v;
            v = TBL[k];
            @(negedge clk);
            dec_valid   = v[59];
            dec_src     = {v[52:50], v[55:53], v[58:56]};
            dec_has_dst = v[49];
            dec_dst     = v[48:46];
            res_valid   = v[45];
            res_tag     = v[44:41];
            res_data    = {4{v[40:25]}};
            take        = v[24];
            @(posedge clk);
            #1;
            idle_inputs();
            check($sformatf("row%0d have R3 R4 R5 R9", k), 192'(op_have), 192'(v[23:21]));
            check($sformatf("row%0d ready R9", k), 192'(slot_ready), 192'(v[20]));
            check($sformatf("row%0d tag R2", k), 192'(dec_tag), 192'(v[19:16]));
            check($sformatf("row%0d data R5 R7 R8 R10", k), 192'(op_data[15:0]), 192'(v[15:0]));
            if (k == 10) begin
                check("R4 upper bits zero", 192'(op_data[63:4]), 192'(0));
            end
        end

        // R2: twelve more destination writers on r4 take tags 4..15, then wrap to 0
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            dec_valid = 1'b1; dec_has_dst = 1'b1; dec_dst = 3'd4; dec_src = '0;
            @(posedge clk);
            #1;
            idle_inputs();
            check("R2 tag step/wrap", 192'(dec_tag), 192'((k + 5) % 16));
        end

        // R4: all three sources read r4, pending with tag 15
        @(negedge clk);
        dec_valid = 1'b1; dec_src = {3'd4, 3'd4, 3'd4};
        @(posedge clk);
        #1;
        idle_inputs();
        check("R4 three tags", op_data, {64'hF, 64'hF, 64'hF});
        check("R4 have", 192'(op_have), 192'(0));

        // R5: one broadcast fills all three operands
        @(negedge clk);
        res_valid = 1'b1; res_tag = 4'd15; res_data = 64'h0123_4567_89AB_CDEF;
        @(posedge clk);
        #1;
        idle_inputs();
        check("R5 multi capture", op_data, {3{64'h0123_4567_89AB_CDEF}});
        check("R5 R9 ready", 192'(slot_ready), 192'(1));

        // R9: take empties the slot and clears data
        @(negedge clk);
        take = 1'b1;
        @(posedge clk);
        #1;
        idle_inputs();
        check("R9 take data", op_data, 192'(0));
        check("R9 take ready", 192'(slot_ready), 192'(0));

        // R1: reset again restores empty slot and counter
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        dec_valid = 1'b1; dec_src = {3'd4, 3'd3, 3'd1};
        @(posedge clk);
        #1;
        idle_inputs();
        check("R1 regs settled after reset", 192'(op_have), 192'(3'b111));
        check("R1 values zero after reset", op_data, 192'(0));
        check("R1 tag after reset", 192'(dec_tag), 192'(0));

        done = 1'b1;
        finish_run();
    end
endmodule